// File: doc/BRIEF.md
# T1 Stress and Pseudorandom Pattern Generator

This block emits a serial DS-1 test bit stream, advancing by one bit on each cycle where the bit enable is high. A 4-bit select code picks the pattern. The fixed patterns are all ones, all zeros, and three short repeating words: one-in-eight, two-in-eight and three-in-twenty-four. Each word has a known ones density and a known longest run of zeros. The pseudorandom patterns are plain maximal-length sequences from 11-, 15-, 20- and 23-stage shift registers, plus a zero-suppressed 20-stage sequence (QRSS) that never emits more than fourteen zeros in a row.

A second output marks the bit that begins each pattern period. A receiving checker can use it to align to the stream. Changing the select code restarts the new pattern from its first bit at the next enabled bit. Framing-bit insertion and line coding are left to blocks downstream.

Top module: `t1_pattern_gen`

## Requirements
- R1: Reset (synchronous, active high) drives `bit_out` and `period_start` to 0. Both outputs change only at clock edges where `bit_en` is high and hold their values otherwise. A hold does not disturb the position within the pattern.
- R2: Select 0 gives all ones and select 1 gives all zeros, each with an 8-bit period. Select codes 10 to 15 behave exactly like select 0.
- R3: Select 2 repeats the word 8'b1000_0000, sent most significant bit first. It holds one 1 per period and its longest zero run, counted across the wrap, is 7.
- R4: Select 3 repeats the word 8'b0100_0010, sent most significant bit first. It holds two 1s per period and its longest zero run, counted across the wrap, is 4.
- R5: Select 4 repeats the 24-bit word 24'h440004, sent most significant bit first. It holds three 1s per period and its longest zero run, counted across the wrap, is 15.
- R6: Selects 6, 7, 8 and 9 give plain PRBS sequences with (N,K) = (11,9), (15,14), (20,3) and (23,18). For each, the first N bits after a start are 1 and bit i = bit(i-N) XOR bit(i-K).
- R7: In the plain PRBS modes `period_start` is high exactly on every (2^N - 1)th bit, counting from the start bit. This gives a period of 2047 for 11 stages and 32767 for 15 stages.
- R8: Select 5 gives QRSS, which is built from a raw sequence with N=20 and K=17 formed as in R6. An output bit is forced to 1 when that raw bit and the 14 raw bits following it are all 0; otherwise it equals the raw bit. No more than 14 zeros ever appear in a row.
- R9: A start happens on the first enabled bit after reset, and on the first enabled bit whose select code differs from the one used for the previous enabled bit. At a start, the selected pattern begins at its first bit and `period_start` is 1.
- R10: `period_start` is 1 only on the first bit of each pattern period. For the fixed words that is every word boundary; for QRSS it is where the raw register returns to its start state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Advance the stream by one bit at this edge |
| pat_sel | input | 4 | Pattern select code |
| bit_out | output | 1 | Serial test bit |
| period_start | output | 1 | High while `bit_out` carries the first bit of a period |

## Verification
The bench compares each pattern bit for bit against models built only from the word values and recurrences in the requirements. It also measures zero runs and ones counts across several word wraps, so a word stored with a shifted or reversed bit order shows up as a wrong run length.

QRSS is run for twenty thousand bits against a model that looks ahead in the raw sequence. A suppression window that is one bit too short or too long changes bits relative to that model. A window that is missing breaks the fourteen-zero limit.

Select changes are made in the middle of a word and while the enable is low. A design that kept the old position would emit a mid-word bit without the period mark. A hold that leaks would skip a bit. Unused codes are driven to confirm they act as all ones.

// File: rtl/t1pg_pkg.sv
package t1pg_pkg;

   localparam int SEL_W     = 4;
   localparam int NUM_WORDS = 5;
   localparam int NUM_PRBS  = 4;
   localparam int WORD_MAX  = 24;
   localparam int QRSS_CODE = NUM_WORDS;
   localparam int PRBS_BASE = NUM_WORDS + 1;
   localparam int NUM_GEN   = PRBS_BASE + NUM_PRBS;

   typedef enum logic [SEL_W-1:0] {
      PAT_ONES   = 4'd0,
      PAT_ZEROS  = 4'd1,
      PAT_1IN8   = 4'd2,
      PAT_2IN8   = 4'd3,
      PAT_3IN24  = 4'd4,
      PAT_QRSS   = 4'd5,
      PAT_PRBS11 = 4'd6,
      PAT_PRBS15 = 4'd7,
      PAT_PRBS20 = 4'd8,
      PAT_PRBS23 = 4'd9
   } pat_sel_e;

   // length of fixed word i (word i is served by select code i)
   function automatic int word_len(input int i);
      return (i == 4) ? 24 : 8;
   endfunction

   // fixed word i, right aligned, sent MSB first
   function automatic logic [WORD_MAX-1:0] word_bits(input int i);
      case (i)
         0:       return 24'h0000FF;
         1:       return 24'h000000;
         2:       return 24'h000080;
         3:       return 24'h000042;
         default: return 24'h440004;
      endcase
   endfunction

   // stage count of plain PRBS generator i
   function automatic int prbs_stages(input int i);
      case (i)
         0:       return 11;
         1:       return 15;
         2:       return 20;
         default: return 23;
      endcase
   endfunction

   // feedback tap of plain PRBS generator i
   function automatic int prbs_tap(input int i);
      case (i)
         0:       return 9;
         1:       return 14;
         2:       return 3;
         default: return 18;
      endcase
   endfunction

endpackage

// File: rtl/t1pg_word_gen.sv
module t1pg_word_gen #(
   parameter int                                 LEN     = 8,
   parameter logic [t1pg_pkg::WORD_MAX-1:0]      PATTERN = 24'h0000FF
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic step,
   output logic bit_o,
   output logic start_o
);
   localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [LEN-1:0]   WORD = PATTERN[LEN-1:0];
   localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

   if (LEN < 2 || LEN > t1pg_pkg::WORD_MAX) begin : g_bad_len
      $error("t1pg_word_gen: LEN out of range");
   end

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] cur;

   always_comb begin
      cur     = load ? '0 : idx_q;
      bit_o   = WORD[LAST - cur];
      start_o = (cur == '0);
   end

   always_ff @(posedge clk) begin
      if (rst)
         idx_q <= '0;
      else if (step)
         idx_q <= (cur == LAST) ? '0 : cur + 1'b1;
   end

   p_idx_in_word_r10: assert property (@(posedge clk) disable iff (rst)
      idx_q <= LAST)
      else $error("word position left the word");

   p_wrap_marks_r10: assert property (@(posedge clk) disable iff (rst)
      step && (cur == LAST) |=> (idx_q == '0))
      else $error("word did not wrap after last bit");

endmodule

// File: rtl/t1pg_lfsr.sv
module t1pg_lfsr #(
   parameter int N     = 11,
   parameter int K     = 9,
   parameter int GUARD = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic step,
   output logic bit_o,
   output logic start_o
);
   localparam logic [N-1:0] SEED = '1;

   if (N < 3 || K < 1 || K >= N) begin : g_bad_taps
      $error("t1pg_lfsr: tap K must lie in 1..N-1");
   end
   if (GUARD < 0 || GUARD >= N) begin : g_bad_guard
      $error("t1pg_lfsr: GUARD must be below N");
   end

   logic [N-1:0] state_q;
   logic [N-1:0] cur;
   logic [N-1:0] nxt;
   logic         raw;

   always_comb begin
      cur     = load ? SEED : state_q;
      raw     = cur[N-1];
      nxt     = {cur[N-2:0], cur[N-1] ^ cur[K-1]};
      start_o = (cur == SEED);
   end

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= SEED;
      else if (step)
         state_q <= nxt;
   end

   p_state_live_r6: assert property (@(posedge clk) disable iff (rst)
      state_q != '0)
      else $error("shift register fell into the all-zero state");

   if (GUARD == 0) begin : g_plain
      assign bit_o = raw;
   end else begin : g_guarded
      localparam int W     = GUARD + 1;
      localparam int RUN_W = $clog2(GUARD + 2);
      logic [W-1:0]     window;
      logic [RUN_W-1:0] run_q;

      always_comb begin
         window = cur[N-1 -: W];
         bit_o  = (window == '0) ? 1'b1 : raw;
      end

      // emitted zero run, kept for the checker below
      always_ff @(posedge clk) begin
         if (rst)
            run_q <= '0;
         else if (step) begin
            if (bit_o)
               run_q <= '0;
            else if (load)
               run_q <= RUN_W'(1);
            else
               run_q <= run_q + 1'b1;
         end
      end

      p_zero_run_r8: assert property (@(posedge clk) disable iff (rst)
         run_q <= RUN_W'(GUARD))
         else $error("zero run longer than the guard limit");
   end

endmodule

// File: rtl/t1_pattern_gen.sv
module t1_pattern_gen #(
   parameter int QRSS_STAGES    = 20,
   parameter int QRSS_TAP       = 17,
   parameter int QRSS_MAX_ZEROS = 14
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       bit_en,
   input  logic [3:0] pat_sel,
   output logic       bit_out,
   output logic       period_start
);
   import t1pg_pkg::*;

   if (NUM_GEN > (1 << SEL_W)) begin : g_bad_codes
      $error("t1_pattern_gen: more generators than select codes");
   end
   if (QRSS_MAX_ZEROS >= QRSS_STAGES) begin : g_bad_qrss
      $error("t1_pattern_gen: QRSS zero limit must be below stage count");
   end

   logic [NUM_GEN-1:0] gen_bit;
   logic [NUM_GEN-1:0] gen_start;
   logic [NUM_GEN-1:0] gen_step;
   logic [SEL_W-1:0]   gen_idx;
   logic [SEL_W-1:0]   sel_q;
   logic               armed_q;
   logic               restart;

   always_comb begin
      // codes without a generator fall back to the all-ones word
      gen_idx = (pat_sel < SEL_W'(NUM_GEN)) ? pat_sel : SEL_W'(PAT_ONES);
      restart = !armed_q || (pat_sel != sel_q);
   end

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_step
      assign gen_step[g] = bit_en && (gen_idx == SEL_W'(g));
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      t1pg_word_gen #(
         .LEN     (word_len(w)),
         .PATTERN (word_bits(w))
      ) u_word (
         .clk     (clk),
         .rst     (rst),
         .load    (restart),
         .step    (gen_step[w]),
         .bit_o   (gen_bit[w]),
         .start_o (gen_start[w])
      );
   end

   t1pg_lfsr #(
      .N     (QRSS_STAGES),
      .K     (QRSS_TAP),
      .GUARD (QRSS_MAX_ZEROS)
   ) u_qrss (
      .clk     (clk),
      .rst     (rst),
      .load    (restart),
      .step    (gen_step[QRSS_CODE]),
      .bit_o   (gen_bit[QRSS_CODE]),
      .start_o (gen_start[QRSS_CODE])
   );

   for (genvar p = 0; p < NUM_PRBS; p++) begin : g_prbs
      t1pg_lfsr #(
         .N     (prbs_stages(p)),
         .K     (prbs_tap(p)),
         .GUARD (0)
      ) u_prbs (
         .clk     (clk),
         .rst     (rst),
         .load    (restart),
         .step    (gen_step[PRBS_BASE+p]),
         .bit_o   (gen_bit[PRBS_BASE+p]),
         .start_o (gen_start[PRBS_BASE+p])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_out      <= 1'b0;
         period_start <= 1'b0;
         sel_q        <= '0;
         armed_q      <= 1'b0;
      end else if (bit_en) begin
         bit_out      <= gen_bit[gen_idx];
         period_start <= gen_start[gen_idx];
         sel_q        <= pat_sel;
         armed_q      <= 1'b1;
      end
   end

   p_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(bit_out) && $stable(period_start))
      else $error("outputs moved without bit enable");

   p_restart_mark_r9: assert property (@(posedge clk) disable iff (rst)
      bit_en && restart |=> period_start)
      else $error("start bit not marked");

   p_ones_r2: assert property (@(posedge clk) disable iff (rst)
      bit_en && (pat_sel == SEL_W'(PAT_ONES)) |=> bit_out)
      else $error("all-ones mode emitted a zero");

   p_zeros_r2: assert property (@(posedge clk) disable iff (rst)
      bit_en && (pat_sel == SEL_W'(PAT_ZEROS)) |=> !bit_out)
      else $error("all-zeros mode emitted a one");

endmodule

// File: tb/t1_pattern_gen_test.sv
module t1_pattern_gen_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bit_en = 1'b0;
   logic [3:0] pat_sel = 4'd0;
   logic       bit_out;
   logic       period_start;

   int checks = 0;
   int failures = 0;

   bit ref_bits [0:20100];

   t1_pattern_gen uut (
      .clk          (clk),
      .rst          (rst),
      .bit_en       (bit_en),
      .pat_sel      (pat_sel),
      .bit_out      (bit_out),
      .period_start (period_start)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act,
                      input int exp, input string what);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(output bit b, output bit s);
      bit_en = 1'b1;
      @(negedge clk);
      b = bit_out;
      s = period_start;
   endtask

   // burn one bit on another code so the next step restarts `code`
   task automatic go(input logic [3:0] code);
      bit b, s;
      pat_sel = code ^ 4'd1;
      step(b, s);
      pat_sel = code;
   endtask

   task automatic t_reset;
      bit b, s;
      repeat (3) @(negedge clk);
      chk(bit_out == 1'b0, "R1", bit_out, 0, "bit_out in reset");
      chk(period_start == 1'b0, "R1", period_start, 0, "period_start in reset");
      rst = 1'b0;
      pat_sel = 4'd2;
      step(b, s);
      chk(b == 1'b1, "R9", b, 1, "first bit after reset");
      chk(s == 1'b1, "R9", s, 1, "start mark after reset");
   endtask

   task automatic t_word(input logic [3:0] code, input int len,
                         input bit [23:0] word, input int exp_run,
                         input int exp_ones, input string tag);
      bit b, s;
      int run = 0, max_run = 0, ones = 0;
      go(code);
      for (int i = 0; i < 3 * len; i++) begin
         step(b, s);
         chk(b == word[len-1-(i%len)], tag, b, word[len-1-(i%len)], "word bit");
         chk(s == (i % len == 0), "R10", s, int'(i % len == 0), "word start mark");
         if (b) run = 0; else run++;
         if (run > max_run) max_run = run;
         if (i < len && b) ones++;
      end
      chk(max_run == exp_run, tag, max_run, exp_run, "longest zero run");
      chk(ones == exp_ones, tag, ones, exp_ones, "ones per period");
   endtask

   task automatic t_hold;
      bit b, s, hb, hs;
      go(4'd4);
      for (int i = 0; i < 5; i++) step(hb, hs);
      bit_en = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(bit_out == hb && period_start == hs, "R1",
             {bit_out, period_start}, {hb, hs}, "held outputs");
      end
      step(b, s);
      chk(b == 1'b1 && s == 1'b0, "R1", {b, s}, 2, "bit after hold resumes in place");
   endtask

   task automatic t_prbs(input logic [3:0] code, input int n, input int k,
                         input int nbits);
      bit b, s;
      int period = (1 << n) - 1;
      for (int i = 0; i < nbits; i++)
         ref_bits[i] = (i < n) ? 1'b1 : (ref_bits[i-n] ^ ref_bits[i-k]);
      go(code);
      for (int i = 0; i < nbits; i++) begin
         step(b, s);
         chk(b == ref_bits[i], "R6", b, ref_bits[i], "prbs bit");
         chk(s == (i % period == 0), "R7", s, int'(i % period == 0), "prbs start mark");
      end
   endtask

   task automatic t_period(input logic [3:0] code, input int period);
      bit b, s;
      int marks = 0;
      go(code);
      for (int i = 0; i <= period; i++) begin
         step(b, s);
         if (s) marks++;
      end
      chk(marks == 2, "R7", marks, 2, "start marks over one period");
      chk(s == 1'b1, "R7", s, 1, "mark at period boundary");
   endtask

   task automatic t_qrss;
      bit b, s, e, allz;
      int len = 20000, run = 0, max_run = 0;
      for (int i = 0; i < len + 15; i++)
         ref_bits[i] = (i < 20) ? 1'b1 : (ref_bits[i-20] ^ ref_bits[i-17]);
      go(4'd5);
      for (int i = 0; i < len; i++) begin
         allz = 1'b1;
         for (int j = 0; j < 15; j++) if (ref_bits[i+j]) allz = 1'b0;
         e = ref_bits[i] | allz;
         step(b, s);
         chk(b == e, "R8", b, e, "qrss bit");
         if (i == 0) chk(s == 1'b1, "R10", s, 1, "qrss start mark");
         if (b) run = 0; else run++;
         if (run > max_run) max_run = run;
      end
      chk(max_run <= 14, "R8", max_run, 14, "qrss zero run");
   endtask

   task automatic t_switch;
      bit b, s;
      go(4'd2);
      for (int i = 0; i < 3; i++) step(b, s);
      pat_sel = 4'd3;
      step(b, s);
      chk(b == 1'b0 && s == 1'b1, "R9", {b, s}, 1, "switch mid-word first bit");
      step(b, s);
      chk(b == 1'b1 && s == 1'b0, "R9", {b, s}, 2, "switch mid-word second bit");
      bit_en = 1'b0;
      pat_sel = 4'd4;
      repeat (3) @(negedge clk);
      chk(bit_out == 1'b1, "R1", bit_out, 1, "select change without enable");
      step(b, s);
      chk(b == 1'b0 && s == 1'b1, "R9", {b, s}, 1, "switch after hold first bit");
      step(b, s);
      chk(b == 1'b1 && s == 1'b0, "R9", {b, s}, 2, "switch after hold second bit");
   endtask

   initial begin
      #(8 * 180000);
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_word(4'd0,  8, 24'h0000FF, 0,  8, "R2");
      t_word(4'd1,  8, 24'h000000, 24, 0, "R2");
      t_word(4'd12, 8, 24'h0000FF, 0,  8, "R2");
      t_word(4'd2,  8, 24'h000080, 7,  1, "R3");
      t_word(4'd3,  8, 24'h000042, 4,  2, "R4");
      t_word(4'd4, 24, 24'h440004, 15, 3, "R5");
      t_hold();
      t_switch();
      t_prbs(4'd6, 11, 9, 3000);
      t_prbs(4'd7, 15, 14, 3000);
      t_prbs(4'd8, 20, 3, 3000);
      t_prbs(4'd9, 23, 18, 3000);
      t_period(4'd6, 2047);
      t_period(4'd7, 32767);
      t_qrss();
      bit_en = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule